// File: doc/BRIEF.md
# I2C Write Engine with Register Interface

This block is a single-master I2C write engine that a small processor drives through four byte-wide registers. Firmware programs the number of data bytes (as a count minus one) and the target byte (7-bit address with the direction bit as its LSB, cleared for a write). It then feeds the data bytes one at a time through a data register. The first data byte given to an idle engine starts the transfer. The engine issues START, shifts out the target byte, then shifts out each data byte MSB first and samples the acknowledge bit after each byte. It ends with STOP after the last counted byte, or as soon as any byte is not acknowledged.

Between bytes, firmware polls a byte-active flag. The flag is set from the moment a byte is accepted until its acknowledge has been sampled. A transaction flag covers the whole transfer until the STOP condition has been driven. A not-acknowledged flag stays readable until the next transaction starts. Both bus lines are open drain: each has an output enable that only ever pulls the line low, and a line input for reading it back.

Each bit period on SCL is built from four equal quarters. The quarter length is the system clock rate divided by the bus rate, divided by four. If a target holds SCL low while the engine has released it, the quarter timer stops until the line rises.

Top module: `i2cw_engine`

## Requirements
- R1: After reset, both line enables are off, every status bit reads 0 and the control register reads 0. Whenever no transaction is in progress, both line enables stay off.
- R2: Register offsets are 0 control (count-minus-one in the low LEN_W bits), 1 target byte, 2 data and 3 status. A read returns its value on the bus one clock after the offset is presented. Writes to offsets 0 and 1 have no effect while a transaction is in progress.
- R3: A data write to an idle engine produces START (SDA falls while SCL is high). The target byte follows exactly as programmed, then the data byte, each MSB first and each followed by a ninth clock for the acknowledge.
- R4: With a control value of N, exactly N+1 data bytes are sent, and STOP follows the acknowledge of the last one.
- R5: Status bit 0 (byte active) is 1 from an accepted data write until that byte's acknowledge has been sampled. A data write that arrives while a byte is active, or while the target byte or START is being sent, has no effect: the byte sent and the byte read back from offset 2 stay those of the accepted write.
- R6: Status bit 1 (in transaction) is 1 from the first accepted data write until the STOP condition (SDA rises while SCL is high) has been driven. It stays 1 while the engine waits for the next data byte.
- R7: A high SDA at the acknowledge sample of any byte sets status bit 2 (NAK) and leads straight to STOP, with no further bytes. The flag clears when the next transaction starts.
- R8: SCL is held low for two quarters and released for two quarters of every bit, where a quarter lasts CLK_HZ/BUS_HZ/4 clocks.
- R9: Apart from START and STOP, the SDA enable changes only while SCL is held low.
- R10: While SCL is released by the engine but read low, the quarter timer holds. A stretched clock still gets its full two quarters high once the line rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Register offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 8 | Register write data |
| bus_rdata | output | 8 | Registered read data for the offset presented |
| scl_in | input | 1 | Level read back from the SCL line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_in | input | 1 | Level read back from the SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The coincidence of interest is the target's hold on SCL meeting the engine's own release of SCL in the same clock. The quarter timer must not count a quarter in that cycle, and it must not stall in a cycle where the line is simply rising. The bench provokes this by having its target model stretch the acknowledge clock of the target byte by three quarters. It judges the result by the measured widths on the wire: the high phase must be exactly two quarters, the low phase longer than three quarters, and the following data byte must still arrive intact.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_ADDR,
    S_AACK,
    S_DATA,
    S_DACK,
    S_WAIT,
    S_STOP
  } seq_state_t;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_TARGET = 2'd1;
  localparam logic [1:0] REG_DATA   = 2'd2;
  localparam logic [1:0] REG_STAT   = 2'd3;

  localparam int STAT_ACTIVE = 0;
  localparam int STAT_TXN    = 1;
  localparam int STAT_NAK    = 2;

endpackage

// File: rtl/i2cw_quarter_timer.sv
module i2cw_quarter_timer #(
  parameter int QLEN = 125
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic hold,
  output logic tick
);

  localparam int CW = (QLEN > 1) ? $clog2(QLEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(QLEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!hold) begin
      if (cnt == LAST) cnt <= '0;
      else             cnt <= cnt + CW'(1);
    end
  end

  assign tick = run && !hold && (cnt == LAST);

  // R10: a stretched line freezes the quarter count
  a_r10_count_frozen: assert property (@(posedge clk) disable iff (rst)
    (run && hold) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/i2cw_regs.sv
module i2cw_regs
  import i2cw_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       bus_addr,
  input  logic             bus_we,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  input  logic             lock,
  input  logic             st_active,
  input  logic             st_nak,
  input  logic [7:0]       tx_byte,
  output logic [LEN_W-1:0] len_m1,
  output logic [7:0]       target_byte,
  output logic             data_wr
);

  logic [7:0] stat_word;

  always_comb begin
    stat_word = '0;
    stat_word[STAT_ACTIVE] = st_active;
    stat_word[STAT_TXN]    = lock;
    stat_word[STAT_NAK]    = st_nak;
  end

  assign data_wr = bus_we && (bus_addr == REG_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      len_m1      <= '0;
      target_byte <= '0;
      bus_rdata   <= '0;
    end else begin
      if (bus_we && !lock) begin
        if (bus_addr == REG_CTRL)   len_m1      <= bus_wdata[LEN_W-1:0];
        if (bus_addr == REG_TARGET) target_byte <= bus_wdata;
      end
      case (bus_addr)
        REG_CTRL:   bus_rdata <= 8'(len_m1);
        REG_TARGET: bus_rdata <= target_byte;
        REG_DATA:   bus_rdata <= tx_byte;
        default:    bus_rdata <= stat_word;
      endcase
    end
  end

  // R2: configuration is frozen during a transaction
  a_r2_target_locked: assert property (@(posedge clk) disable iff (rst)
    (lock && bus_we && bus_addr == REG_TARGET) |=> $stable(target_byte));
  a_r2_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
    (lock && bus_we && bus_addr == REG_CTRL) |=> $stable(len_m1));

endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq
  import i2cw_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             data_wr,
  input  logic [7:0]       data_in,
  input  logic [7:0]       target_byte,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             sda_in,
  output logic             run,
  output logic             scl_low,
  output logic             sda_low,
  output logic             byte_act,
  output logic             in_txn,
  output logic             nak,
  output logic [7:0]       tx_byte
);

  seq_state_t       st;
  logic [1:0]       q;
  logic [2:0]       bitc;
  logic [7:0]       sh;
  logic [LEN_W-1:0] remain;
  logic             ack_bad;
  logic             accept;
  logic             is_ack;
  logic             is_bit;

  assign accept = data_wr && (st == S_IDLE || st == S_WAIT);
  assign run    = !(st == S_IDLE || st == S_WAIT);
  assign in_txn = (st != S_IDLE);
  assign is_ack = (st == S_AACK) || (st == S_DACK);
  assign is_bit = (st == S_ADDR) || (st == S_DATA);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      q        <= '0;
      bitc     <= '0;
      sh       <= '0;
      remain   <= '0;
      ack_bad  <= 1'b0;
      scl_low  <= 1'b0;
      sda_low  <= 1'b0;
      byte_act <= 1'b0;
      nak      <= 1'b0;
      tx_byte  <= '0;
    end else if (accept) begin
      tx_byte  <= data_in;
      byte_act <= 1'b1;
      q        <= '0;
      bitc     <= '0;
      if (st == S_IDLE) begin
        st     <= S_START;
        nak    <= 1'b0;
        remain <= len_m1;
        sh     <= target_byte;
      end else begin
        st      <= S_DATA;
        sh      <= data_in;
        scl_low <= 1'b1;
      end
    end else if (tick) begin
      if (q == 2'd3) begin
        // slot boundary: pick the next slot and enter its first quarter
        q <= '0;
        case (st)
          S_START: begin
            st      <= S_ADDR;
            bitc    <= '0;
            scl_low <= 1'b1;
          end
          S_ADDR, S_DATA: begin
            scl_low <= 1'b1;
            sh      <= {sh[6:0], 1'b0};
            if (bitc == 3'd7) st <= (st == S_ADDR) ? S_AACK : S_DACK;
            else              bitc <= bitc + 3'd1;
          end
          S_AACK: begin
            scl_low <= 1'b1;
            if (ack_bad) begin
              st       <= S_STOP;
              byte_act <= 1'b0;
            end else begin
              st   <= S_DATA;
              sh   <= tx_byte;
              bitc <= '0;
            end
          end
          S_DACK: begin
            byte_act <= 1'b0;
            if (ack_bad || remain == '0) begin
              st      <= S_STOP;
              scl_low <= 1'b1;
            end else begin
              st     <= S_WAIT;
              remain <= remain - LEN_W'(1);
            end
          end
          default: st <= S_IDLE;
        endcase
      end else begin
        q <= q + 2'd1;
        case (q)
          2'd0: begin
            // second quarter: SCL is low, SDA may move
            if (is_bit)            sda_low <= ~sh[7];
            else if (is_ack)       sda_low <= 1'b0;
            else if (st == S_STOP) sda_low <= 1'b1;
          end
          2'd1: begin
            scl_low <= 1'b0;
            if (st == S_START) sda_low <= 1'b1;
          end
          2'd2: begin
            if (is_ack) begin
              ack_bad <= sda_in;
              if (sda_in) nak <= 1'b1;
            end
            if (st == S_STOP) sda_low <= 1'b0;
          end
          default: ;
        endcase
      end
    end
  end

  // R9: SDA stays put while SCL is released, outside START/STOP slots
  a_r9_sda_quiet_high: assert property (@(posedge clk) disable iff (rst)
    (!scl_low && !$past(scl_low)
     && !(st inside {S_START, S_STOP}) && !($past(st) inside {S_START, S_STOP}))
    |-> (sda_low == $past(sda_low)));

  // R7: a refused byte goes straight to the STOP slot
  a_r7_nak_to_stop: assert property (@(posedge clk) disable iff (rst)
    (tick && q == 2'd3 && is_ack && ack_bad) |=> (st == S_STOP));

  // R6: every transaction ends through the STOP slot
  a_r6_end_via_stop: assert property (@(posedge clk) disable iff (rst)
    (st == S_IDLE && $past(st) != S_IDLE) |-> ($past(st) == S_STOP));

  // R5: a byte in flight implies an open transaction
  a_r5_active_in_txn: assert property (@(posedge clk) disable iff (rst)
    byte_act |-> in_txn);

endmodule

// File: rtl/i2cw_engine.sv
module i2cw_engine
  import i2cw_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000,
  parameter int BUS_HZ = 400_000,
  parameter int LEN_W  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] bus_addr,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       scl_in,
  output logic       scl_oe,
  input  logic       sda_in,
  output logic       sda_oe
);

  localparam int QLEN = CLK_HZ / BUS_HZ / 4;

  logic             run;
  logic             tick;
  logic             hold;
  logic             scl_low;
  logic             sda_low;
  logic             byte_act;
  logic             in_txn;
  logic             nak;
  logic [7:0]       tx_byte;
  logic [7:0]       target_byte;
  logic [LEN_W-1:0] len_m1;
  logic             data_wr;

  // line read low although the engine has let it go: a target is stretching
  assign hold = !scl_low && !scl_in;

  i2cw_quarter_timer #(.QLEN(QLEN)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .hold (hold),
    .tick (tick)
  );

  i2cw_regs #(.LEN_W(LEN_W)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .bus_wdata   (bus_wdata),
    .bus_rdata   (bus_rdata),
    .lock        (in_txn),
    .st_active   (byte_act),
    .st_nak      (nak),
    .tx_byte     (tx_byte),
    .len_m1      (len_m1),
    .target_byte (target_byte),
    .data_wr     (data_wr)
  );

  i2cw_seq #(.LEN_W(LEN_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .data_wr     (data_wr),
    .data_in     (bus_wdata),
    .target_byte (target_byte),
    .len_m1      (len_m1),
    .sda_in      (sda_in),
    .run         (run),
    .scl_low     (scl_low),
    .sda_low     (sda_low),
    .byte_act    (byte_act),
    .in_txn      (in_txn),
    .nak         (nak),
    .tx_byte     (tx_byte)
  );

  assign scl_oe = scl_low;
  assign sda_oe = sda_low;

  // R1: with no transaction open, both lines are left to the pull-ups
  a_r1_idle_released: assert property (@(posedge clk) disable iff (rst)
    !in_txn |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/sim_i2cw_engine.sv
`timescale 1ns/1ps
module sim_i2cw_engine;

  localparam int CLK_HZ = 200_000_000;
  localparam int BUS_HZ = 2_000_000;
  localparam int LEN_W  = 4;
  localparam int Q      = CLK_HZ / BUS_HZ / 4;
  localparam int STR    = 3 * Q;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] bus_addr = '0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       scl_oe, sda_oe;
  logic       sl_scl_low = 1'b0;
  logic       sl_sda_low = 1'b0;
  logic       scl_w, sda_w;

  assign scl_w = !(scl_oe || sl_scl_low);
  assign sda_w = !(sda_oe || sl_sda_low);

  always #2.5 clk = ~clk;

  i2cw_engine #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ), .LEN_W(LEN_W)) u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .scl_in(scl_w), .scl_oe(scl_oe), .sda_in(sda_w), .sda_oe(sda_oe)
  );

  int n_chk = 0;
  int n_bad = 0;

  // target model
  int         bitn = 0, rx_n = 0, starts = 0, stops = 0;
  int         nak_at = -1, str_at = -1, str_cnt = 0;
  int         run_len = 0, ack_hi = 0, ack_lo = 0;
  logic [7:0] sh = '0;
  logic [7:0] rx [16];
  logic       scl_p = 1'b1, sda_p = 1'b1, in_frame = 1'b0;

  always @(posedge clk) begin
    if (str_cnt > 0) begin
      str_cnt <= str_cnt - 1;
      if (str_cnt == 1) sl_scl_low <= 1'b0;
    end
    if (scl_w == scl_p) run_len <= run_len + 1;
    else                run_len <= 1;
    if (scl_w && scl_p && sda_p && !sda_w) begin
      starts <= starts + 1; bitn <= 0; in_frame <= 1'b1;
    end else if (scl_w && scl_p && !sda_p && sda_w) begin
      stops <= stops + 1; in_frame <= 1'b0;
    end else if (in_frame && scl_w && !scl_p) begin
      if (bitn < 8) begin
        sh <= {sh[6:0], sda_w}; bitn <= bitn + 1;
      end else begin
        bitn <= 9;
        if (rx_n == 1) ack_lo <= run_len;
      end
    end else if (in_frame && !scl_w && scl_p) begin
      if (bitn == 8) begin
        rx[rx_n]   <= sh;
        rx_n       <= rx_n + 1;
        sl_sda_low <= (rx_n != nak_at);
        if (rx_n == str_at) begin
          sl_scl_low <= 1'b1; str_cnt <= STR;
        end
      end else if (bitn == 9) begin
        sl_sda_low <= 1'b0; bitn <= 0;
        if (rx_n == 1) ack_hi <= run_len;
      end
    end
    scl_p <= scl_w;
    sda_p <= sda_w;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_clear(input int b);
    logic [7:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_rd(2'd3, v);
      if (!v[b]) return;
    end
  endtask

  task automatic slave_reset(input int nk, input int st);
    @(negedge clk);
    rx_n = 0; starts = 0; stops = 0; nak_at = nk; str_at = st;
    ack_hi = 0; ack_lo = 0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
    reg_rd(2'd3, v); chk("R1 status", v, 8'h00);
    reg_rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    reg_wr(2'd0, 8'h02); reg_wr(2'd1, 8'hA4);
    reg_rd(2'd0, v); chk("R2 ctrl readback", v, 8'h02);
    reg_rd(2'd1, v); chk("R2 target readback", v, 8'hA4);
  endtask

  task automatic t_single;
    logic [7:0] v;
    slave_reset(-1, -1);
    reg_wr(2'd0, 8'h00); reg_wr(2'd1, 8'hA4); reg_wr(2'd2, 8'h5A);
    reg_rd(2'd3, v); chk("R5 status during byte", v, 8'h03);
    wait_clear(1);
    chk("R3 byte count", rx_n, 2);
    chk("R3 target byte", rx[0], 8'hA4);
    chk("R3 data byte", rx[1], 8'h5A);
    chk("R9 starts", starts, 1);
    chk("R6 stops", stops, 1);
    reg_rd(2'd3, v); chk("R6 status after stop", v, 8'h00);
    chk("R8 ack high width", ack_hi, 2 * Q);
    chk("R8 ack low width", ack_lo, 2 * Q);
    chk("R1 lines free", int'(scl_oe || sda_oe), 0);
  endtask

  task automatic t_multi;
    logic [7:0] v;
    slave_reset(-1, -1);
    reg_wr(2'd0, 8'h02); reg_wr(2'd1, 8'h3C);
    reg_wr(2'd2, 8'h11);
    reg_wr(2'd2, 8'hEE);
    reg_rd(2'd2, v); chk("R5 ignored data write", v, 8'h11);
    reg_wr(2'd1, 8'h77);
    reg_rd(2'd1, v); chk("R2 locked target", v, 8'h3C);
    reg_wr(2'd0, 8'h05);
    reg_rd(2'd0, v); chk("R2 locked ctrl", v, 8'h02);
    wait_clear(0);
    reg_rd(2'd3, v); chk("R6 waiting status", v, 8'h02);
    reg_wr(2'd2, 8'h22);
    wait_clear(0);
    reg_wr(2'd2, 8'h33);
    wait_clear(1);
    chk("R4 byte count", rx_n, 4);
    chk("R5 first byte kept", rx[1], 8'h11);
    chk("R4 second byte", rx[2], 8'h22);
    chk("R4 third byte", rx[3], 8'h33);
    chk("R4 one stop", stops, 1);
    chk("R9 one start", starts, 1);
  endtask

  task automatic t_nak_data;
    logic [7:0] v;
    slave_reset(2, -1);
    reg_wr(2'd0, 8'h02); reg_wr(2'd1, 8'h50);
    reg_wr(2'd2, 8'hAA);
    wait_clear(0);
    reg_wr(2'd2, 8'hBB);
    wait_clear(1);
    reg_rd(2'd3, v); chk("R7 nak status", v, 8'h04);
    chk("R7 no byte after nak", rx_n, 3);
    chk("R7 stop after nak", stops, 1);
  endtask

  task automatic t_nak_addr;
    logic [7:0] v;
    slave_reset(0, -1);
    reg_wr(2'd0, 8'h00); reg_wr(2'd1, 8'h90); reg_wr(2'd2, 8'h12);
    wait_clear(1);
    reg_rd(2'd3, v); chk("R7 target nak status", v, 8'h04);
    chk("R7 data not sent", rx_n, 1);
    chk("R7 stop after target nak", stops, 1);
    slave_reset(-1, -1);
    reg_wr(2'd1, 8'hA0); reg_wr(2'd2, 8'h34);
    reg_rd(2'd3, v); chk("R7 nak cleared at start", v, 8'h03);
    wait_clear(1);
    chk("R7 next data byte", rx[1], 8'h34);
  endtask

  task automatic t_stretch;
    slave_reset(-1, 0);
    reg_wr(2'd0, 8'h00); reg_wr(2'd1, 8'h42); reg_wr(2'd2, 8'h99);
    wait_clear(1);
    chk("R10 high width after stretch", ack_hi, 2 * Q);
    chk("R10 low stretched", int'(ack_lo > 3 * Q), 1);
    chk("R10 data intact", rx[1], 8'h99);
    chk("R10 stop", stops, 1);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_single();
    t_multi();
    t_nak_data();
    t_nak_addr();
    t_stretch();
    finish_run();
  end

endmodule